// File: doc/BRIEF.md
# Host Default-Endpoint Control and Status Register

This block holds the eight control and status flags of the default control endpoint on the host side of a USB controller. Software reads and writes the flags as one byte. A transaction engine reads the requested token, the data-toggle value and a transaction request from the block, and reports each bus outcome back as a one-cycle event code.

The flags are coupled. A SETUP request forces DATA0 and a status-stage request forces DATA1. Receiving data clears the IN request. A completed stage clears the status-stage flag. Two counters can halt the endpoint: one counts frames spent in a run of NAK handshakes against a programmable limit, and one counts transactions that got no response. Each event that software must see produces a single-cycle interrupt pulse.

Top module: `ep0_host_ctl`

## Requirements
- R1: After reset all eight flags read 0, the data toggle is 0, and both the transaction request and the interrupt are low.
- R2: The register byte holds, from bit 7 down to bit 0: NAK-timeout, status-stage, request-IN, error, setup, stalled, tx-ready, rx-ready. A write loads all eight bits, and the read port always shows the current flags.
- R3: The token output is SETUP (code 2) when tx-ready and setup are both set, OUT (code 0) when only tx-ready is set, and IN (code 1) when only request-IN is set. Tx-ready takes priority over request-IN.
- R4: A write with setup set loads toggle 0. A write with status-stage set and setup clear loads toggle 1. Every ACK event (code 1) and every DATA event (code 2) inverts the toggle.
- R5: An ACK event clears tx-ready, setup and status-stage.
- R6: A DATA event sets rx-ready and clears request-IN and status-stage. A software write in the same cycle is applied first, so the event still wins.
- R7: A STALL event (code 4) sets stalled and clears tx-ready, request-IN and status-stage. Only a software write clears stalled.
- R8: The third consecutive NO-RESPONSE event (code 5) sets the error flag. An ACK, DATA, NAK (code 3) or STALL event restarts the count.
- R9: After a NAK event, each frame tick advances a frame count. When the count reaches a nonzero limit, NAK-timeout is set. An ACK, DATA or STALL event clears the run. A limit of 0 never times out.
- R10: The transaction request is high exactly when tx-ready or request-IN is set and neither NAK-timeout nor error is set.
- R11: ACK, DATA, STALL, the error being raised, or the NAK timeout raises the interrupt for exactly one cycle, in the cycle after the cause. Causes that coincide give a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Software byte write strobe |
| reg_wr_data | input | 8 | Software write byte |
| reg_rd_data | output | 8 | Current flag byte |
| nak_limit | input | 5 | NAK timeout in frames, 0 disables |
| frame_tick | input | 1 | One-cycle start-of-frame marker |
| ev_code | input | 3 | Engine outcome: 0 none, 1 ACK, 2 DATA, 3 NAK, 4 STALL, 5 no response |
| xact_req | output | 1 | Transaction request to the engine |
| xact_token | output | 2 | Token to send: 0 OUT, 1 IN, 2 SETUP |
| data_toggle | output | 1 | Data PID toggle: 0 DATA0, 1 DATA1 |
| ep_irq | output | 1 | Endpoint interrupt pulse |

## Verification
A DATA event can land in the same cycle as a software write that clears rx-ready and request-IN. The bench issues both together and expects rx-ready set, request-IN clear and the toggle inverted. The third no-response event can also coincide with the frame tick that ends a NAK run. The bench lines these up under a two-frame limit and expects both the error flag and the NAK-timeout flag set, one interrupt pulse, and a low interrupt on the following cycle.

// File: rtl/ep0h_pkg.sv
package ep0h_pkg;

    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_ACK    = 3'd1,
        EV_DATA   = 3'd2,
        EV_NAK    = 3'd3,
        EV_STALL  = 3'd4,
        EV_NORESP = 3'd5
    } ep0h_ev_e;

    typedef enum logic [1:0] {
        TOK_OUT   = 2'd0,
        TOK_IN    = 2'd1,
        TOK_SETUP = 2'd2
    } ep0h_tok_e;

    // Packed MSB first so that the register byte maps straight onto it.
    typedef struct packed {
        logic nak_halt;
        logic status_stg;
        logic req_in;
        logic no_resp_err;
        logic setup_tok;
        logic stall_seen;
        logic tx_ready;
        logic rx_ready;
    } ep0h_flags_t;

    typedef struct packed {
        logic ack;
        logic data;
        logic nak;
        logic stall;
        logic noresp;
    } ep0h_evdec_t;

    function automatic ep0h_evdec_t decode_ev(input ep0h_ev_e e);
        ep0h_evdec_t d;
        d.ack    = (e == EV_ACK);
        d.data   = (e == EV_DATA);
        d.nak    = (e == EV_NAK);
        d.stall  = (e == EV_STALL);
        d.noresp = (e == EV_NORESP);
        return d;
    endfunction

    function automatic ep0h_tok_e pick_token(input ep0h_flags_t f);
        if (f.tx_ready)
            return f.setup_tok ? TOK_SETUP : TOK_OUT;
        return TOK_IN;
    endfunction

endpackage

// File: rtl/ep0h_retry_ctr.sv
module ep0h_retry_ctr #(
    parameter int RETRY_MAX = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic noresp,
    input  logic restart,
    output logic err_hit
);
    generate
        if (RETRY_MAX > 1) begin : g_count
            localparam int CW = $clog2(RETRY_MAX + 1);
            localparam logic [CW-1:0] LAST = CW'(RETRY_MAX - 1);
            logic [CW-1:0] cnt;

            assign err_hit = noresp && (cnt == LAST);

            always_ff @(posedge clk) begin
                if (rst || restart || err_hit)
                    cnt <= '0;
                else if (noresp)
                    cnt <= cnt + CW'(1);
            end
        end else begin : g_single
            logic unused_in;
            assign unused_in = clk ^ rst ^ restart;
            assign err_hit = noresp;
        end
    endgenerate
endmodule

// File: rtl/ep0h_nak_timer.sv
module ep0h_nak_timer #(
    parameter int NAK_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             nak_seen,
    input  logic             resp_other,
    input  logic             frame_tick,
    input  logic [NAK_W-1:0] limit,
    output logic             nak_hit
);
    logic             active;
    logic [NAK_W-1:0] frames;
    logic             enabled;

    assign enabled = (limit != '0);
    assign nak_hit = active && frame_tick && enabled && ((frames + NAK_W'(1)) == limit);

    always_ff @(posedge clk) begin
        if (rst || resp_other || nak_hit) begin
            active <= 1'b0;
            frames <= '0;
        end else begin
            if (nak_seen)
                active <= 1'b1;
            if (active && frame_tick && enabled)
                frames <= frames + NAK_W'(1);
        end
    end
endmodule

// File: rtl/ep0h_flag_file.sv
module ep0h_flag_file
    import ep0h_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        ev_ack,
    input  logic        ev_data,
    input  logic        ev_stall,
    input  logic        err_hit,
    input  logic        nak_hit,
    output ep0h_flags_t flags,
    output logic        toggle,
    output logic        irq
);
    ep0h_flags_t nxt;
    logic        tgl_nxt;
    logic        irq_nxt;

    always_comb begin
        nxt     = flags;
        tgl_nxt = toggle;
        if (wr_en) begin
            nxt = ep0h_flags_t'(wr_data);
            if (nxt.setup_tok)
                tgl_nxt = 1'b0;
            else if (nxt.status_stg)
                tgl_nxt = 1'b1;
        end
        if (ev_ack) begin
            nxt.tx_ready   = 1'b0;
            nxt.setup_tok  = 1'b0;
            nxt.status_stg = 1'b0;
            tgl_nxt        = ~tgl_nxt;
        end
        if (ev_data) begin
            nxt.rx_ready   = 1'b1;
            nxt.req_in     = 1'b0;
            nxt.status_stg = 1'b0;
            tgl_nxt        = ~tgl_nxt;
        end
        if (ev_stall) begin
            nxt.stall_seen = 1'b1;
            nxt.tx_ready   = 1'b0;
            nxt.req_in     = 1'b0;
            nxt.status_stg = 1'b0;
        end
        if (err_hit)
            nxt.no_resp_err = 1'b1;
        if (nak_hit)
            nxt.nak_halt = 1'b1;
        irq_nxt = ev_ack | ev_data | ev_stall | err_hit | nak_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '0;
            toggle <= 1'b0;
            irq    <= 1'b0;
        end else begin
            flags  <= nxt;
            toggle <= tgl_nxt;
            irq    <= irq_nxt;
        end
    end
endmodule

// File: rtl/ep0_host_ctl.sv
module ep0_host_ctl
    import ep0h_pkg::*;
#(
    parameter int NAK_W     = 5,
    parameter int RETRY_MAX = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic [7:0]       reg_wr_data,
    output logic [7:0]       reg_rd_data,
    input  logic [NAK_W-1:0] nak_limit,
    input  logic             frame_tick,
    input  logic [2:0]       ev_code,
    output logic             xact_req,
    output logic [1:0]       xact_token,
    output logic             data_toggle,
    output logic             ep_irq
);
    ep0h_evdec_t evd;
    ep0h_flags_t flags;
    logic        err_hit;
    logic        nak_hit;

    assign evd = decode_ev(ep0h_ev_e'(ev_code));

    ep0h_retry_ctr #(.RETRY_MAX(RETRY_MAX)) u_retry (
        .clk     (clk),
        .rst     (rst),
        .noresp  (evd.noresp),
        .restart (evd.ack | evd.data | evd.nak | evd.stall),
        .err_hit (err_hit)
    );

    ep0h_nak_timer #(.NAK_W(NAK_W)) u_nak (
        .clk        (clk),
        .rst        (rst),
        .nak_seen   (evd.nak),
        .resp_other (evd.ack | evd.data | evd.stall),
        .frame_tick (frame_tick),
        .limit      (nak_limit),
        .nak_hit    (nak_hit)
    );

    ep0h_flag_file u_flags (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .ev_ack   (evd.ack),
        .ev_data  (evd.data),
        .ev_stall (evd.stall),
        .err_hit  (err_hit),
        .nak_hit  (nak_hit),
        .flags    (flags),
        .toggle   (data_toggle),
        .irq      (ep_irq)
    );

    assign reg_rd_data = flags;
    assign xact_req    = (flags.tx_ready | flags.req_in) & ~flags.nak_halt & ~flags.no_resp_err;
    assign xact_token  = pick_token(flags);
endmodule

// File: rtl/ep0h_checker.sv
module ep0h_checker #(
    parameter int NAK_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr_en,
    input logic [7:0]       reg_wr_data,
    input logic [7:0]       reg_rd_data,
    input logic [NAK_W-1:0] nak_limit,
    input logic             frame_tick,
    input logic [2:0]       ev_code,
    input logic             xact_req,
    input logic [1:0]       xact_token,
    input logic             data_toggle,
    input logic             ep_irq
);
    // R10: halted endpoint issues no request
    a_r10_halt_blocks: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_data[7] || reg_rd_data[4]) |-> !xact_req);

    // R3: setup with tx-ready selects the SETUP token
    a_r3_setup_token: assert property (@(posedge clk) disable iff (rst)
        (xact_req && reg_rd_data[1] && reg_rd_data[3]) |-> (xact_token == 2'd2));

    // R4: a write of setup alone loads DATA0
    a_r4_setup_data0: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wr_data[3] && ev_code == 3'd0) |=> !data_toggle);

    // R5: ACK retires tx-ready
    a_r5_ack_clears_tx: assert property (@(posedge clk) disable iff (rst)
        (ev_code == 3'd1) |=> !reg_rd_data[1]);

    // R6: DATA sets rx-ready and drops request-IN
    a_r6_data_rx: assert property (@(posedge clk) disable iff (rst)
        (ev_code == 3'd2) |=> (reg_rd_data[0] && !reg_rd_data[5]));

    // R7: STALL sets stalled
    a_r7_stall_seen: assert property (@(posedge clk) disable iff (rst)
        (ev_code == 3'd4) |=> reg_rd_data[2]);

    // R11: interrupt only follows an event or a frame tick
    a_r11_irq_cause: assert property (@(posedge clk) disable iff (rst)
        ep_irq |-> ($past(ev_code) != 3'd0 || $past(frame_tick)));

    logic unused_chk;
    assign unused_chk = ^nak_limit;
endmodule

bind ep0_host_ctl ep0h_checker #(.NAK_W(NAK_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .nak_limit   (nak_limit),
    .frame_tick  (frame_tick),
    .ev_code     (ev_code),
    .xact_req    (xact_req),
    .xact_token  (xact_token),
    .data_toggle (data_toggle),
    .ep_irq      (ep_irq)
);

// File: tb/ep0_host_ctl_bench.sv
module ep0_host_ctl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic [7:0] reg_rd_data;
    logic [4:0] nak_limit = 5'd3;
    logic       frame_tick = 1'b0;
    logic [2:0] ev_code = 3'd0;
    logic       xact_req;
    logic [1:0] xact_token;
    logic       data_toggle;
    logic       ep_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    ep0_host_ctl u_ep0_host_ctl (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .nak_limit(nak_limit), .frame_tick(frame_tick),
        .ev_code(ev_code), .xact_req(xact_req), .xact_token(xact_token),
        .data_toggle(data_toggle), .ep_irq(ep_irq)
    );

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic       irq;
        logic       req;
        int         tok;   // -1: not compared
        int         tgl;   // -1: not compared
    } exp_t;

    exp_t sb[$];

    task automatic push(string tag, logic [7:0] rd, logic irq, logic req, int tok, int tgl);
        exp_t e;
        e.tag = tag; e.rd = rd; e.irq = irq; e.req = req; e.tok = tok; e.tgl = tgl;
        sb.push_back(e);
    endtask

    // Drive one cycle of stimulus starting just after a rising edge.
    task automatic step(bit wr, logic [7:0] wd, logic [2:0] ev, bit tick);
        reg_wr_en = wr; reg_wr_data = wd; ev_code = ev; frame_tick = tick;
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0; reg_wr_data = 8'h00; ev_code = 3'd0; frame_tick = 1'b0;
    endtask

    task automatic wr(logic [7:0] wd);
        step(1'b1, wd, 3'd0, 1'b0);
    endtask

    task automatic ev(logic [2:0] e);
        step(1'b0, 8'h00, e, 1'b0);
    endtask

    task automatic tick();
        step(1'b0, 8'h00, 3'd0, 1'b1);
    endtask

    task automatic fail_line(string tag, string what, int act, int exp);
        n_bad++;
        $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    endtask

    // Monitor: compares each queued expectation at the falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (reg_rd_data !== e.rd) fail_line(e.tag, "flags", int'(reg_rd_data), int'(e.rd));
            if (ep_irq !== e.irq)     fail_line(e.tag, "irq", int'(ep_irq), int'(e.irq));
            if (xact_req !== e.req)   fail_line(e.tag, "req", int'(xact_req), int'(e.req));
            if (e.tok >= 0 && int'(xact_token) != e.tok)
                fail_line(e.tag, "token", int'(xact_token), e.tok);
            if (e.tgl >= 0 && int'(data_toggle) != e.tgl)
                fail_line(e.tag, "toggle", int'(data_toggle), e.tgl);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        push("R1 reset", 8'h00, 0, 0, -1, 0);
        @(posedge clk); #1;

        // R2 R3 R4: SETUP stage with DATA0
        wr(8'h0A);      push("R2 R3 R4 setup write", 8'h0A, 0, 1, 2, 0);
        ev(3'd1);       push("R5 R4 ack setup", 8'h00, 1, 0, -1, 1);
        @(posedge clk); #1; push("R11 single pulse", 8'h00, 0, 0, -1, 1);

        // IN data stage
        wr(8'h20);      push("R3 request IN", 8'h20, 0, 1, 1, 1);
        ev(3'd2);       push("R6 data in", 8'h01, 1, 0, -1, 0);
        wr(8'h00);      push("R2 clear rx", 8'h00, 0, 0, -1, 0);

        // Status stage forces DATA1
        wr(8'h42);      push("R4 status DATA1", 8'h42, 0, 1, 0, 1);
        ev(3'd1);       push("R5 status done", 8'h00, 1, 0, -1, 0);

        // DATA event colliding with a clearing write
        wr(8'h20);      push("R3 request IN again", 8'h20, 0, 1, 1, 0);
        step(1'b1, 8'h00, 3'd2, 1'b0);
                        push("R6 data beats write", 8'h01, 1, 0, -1, 1);
        wr(8'h00);      push("R2 clear rx again", 8'h00, 0, 0, -1, 1);

        // Three missing responses
        wr(8'h02);      push("R3 OUT token", 8'h02, 0, 1, 0, -1);
        ev(3'd5);       push("R8 miss 1", 8'h02, 0, 1, -1, -1);
        ev(3'd5);       push("R8 miss 2", 8'h02, 0, 1, -1, -1);
        ev(3'd5);       push("R8 R10 miss 3", 8'h12, 1, 0, -1, -1);
        wr(8'h02);      push("R10 error cleared", 8'h02, 0, 1, 0, -1);
        ev(3'd3);       push("R8 nak restarts", 8'h02, 0, 1, -1, -1);
        ev(3'd5);       push("R8 miss after restart", 8'h02, 0, 1, -1, -1);
        ev(3'd5);       push("R8 miss after restart 2", 8'h02, 0, 1, -1, -1);
        ev(3'd1);       push("R5 ack out", 8'h00, 1, 0, -1, -1);

        // NAK timeout with limit 3
        wr(8'h20);      push("R3 IN for nak", 8'h20, 0, 1, 1, -1);
        ev(3'd3);       push("R9 nak", 8'h20, 0, 1, -1, -1);
        tick();         push("R9 frame 1", 8'h20, 0, 1, -1, -1);
        tick();         push("R9 frame 2", 8'h20, 0, 1, -1, -1);
        tick();         push("R9 R10 timeout", 8'hA0, 1, 0, -1, -1);
        wr(8'h20);      push("R10 timeout cleared", 8'h20, 0, 1, 1, -1);

        // Streak broken by data
        ev(3'd3);       push("R9 nak run", 8'h20, 0, 1, -1, -1);
        tick();         push("R9 run frame 1", 8'h20, 0, 1, -1, -1);
        tick();         push("R9 run frame 2", 8'h20, 0, 1, -1, -1);
        ev(3'd2);       push("R9 R6 data breaks run", 8'h01, 1, 0, -1, -1);
        wr(8'h20);      push("R2 rearm IN", 8'h20, 0, 1, 1, -1);
        ev(3'd3);       push("R9 new run", 8'h20, 0, 1, -1, -1);
        tick();         push("R9 new frame 1", 8'h20, 0, 1, -1, -1);
        tick();         push("R9 new frame 2", 8'h20, 0, 1, -1, -1);
        tick();         push("R9 new timeout", 8'hA0, 1, 0, -1, -1);
        wr(8'h20);      push("R10 rearm", 8'h20, 0, 1, 1, -1);

        // Limit 0 disables
        nak_limit = 5'd0;
        ev(3'd3);       push("R9 nak limit 0", 8'h20, 0, 1, -1, -1);
        for (int i = 0; i < 5; i++) begin
            tick();     push("R9 no timeout at 0", 8'h20, 0, 1, -1, -1);
        end

        // STALL handshake
        ev(3'd4);       push("R7 stall", 8'h04, 1, 0, -1, -1);
        @(posedge clk); #1; push("R7 stall sticky", 8'h04, 0, 0, -1, -1);
        wr(8'h00);      push("R7 sw clears stall", 8'h00, 0, 0, -1, -1);

        // tx-ready wins over request-IN
        wr(8'h22);      push("R3 tx priority", 8'h22, 0, 1, 0, -1);
        wr(8'h00);      push("R2 clear all", 8'h00, 0, 0, -1, -1);

        // Coincident error and NAK timeout
        nak_limit = 5'd2;
        wr(8'h02);      push("R3 OUT for merge", 8'h02, 0, 1, 0, -1);
        ev(3'd3);       push("R9 merge nak", 8'h02, 0, 1, -1, -1);
        tick();         push("R9 merge frame 1", 8'h02, 0, 1, -1, -1);
        ev(3'd5);       push("R8 merge miss 1", 8'h02, 0, 1, -1, -1);
        ev(3'd5);       push("R8 merge miss 2", 8'h02, 0, 1, -1, -1);
        step(1'b0, 8'h00, 3'd5, 1'b1);
                        push("R11 R8 R9 merged", 8'h92, 1, 0, -1, -1);
        @(posedge clk); #1; push("R11 one pulse only", 8'h92, 0, 0, -1, -1);

        @(posedge clk); #1;
        @(posedge clk); #1;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule